// File: doc/BRIEF.md
# Repeater Operating Mode Controller

This block is the control state machine of one serial-video repeater. Each reference-clock cycle it chooses one of five operating modes: powered down, standby, acquiring lock, passing data as a redriver, or passing data as a retimer. It then drives the enables for the output drivers and the clock/data recovery (CDR) path to match. It takes as inputs:

- the output-enable pin;
- the sink hot-plug level;
- a control word written by the configuration logic;
- a clock-valid flag from an activity detector;
- a pixel-clock measurement, given as a count per reference window and qualified by a strobe.

Whether the path runs as a retimer or a redriver depends on a two-bit function mode. In its automatic setting, the measured rate decides. When the path enters the retimer, or the rate moves, the block opens a timed acquisition window. The output drivers can optionally be blanked during that window. Polarity swap is applied only while the CDR path is in use. Holding output-enable low for long enough returns all configuration to its reset values.

Top module: `rtmr_mode_ctrl`

## Requirements
- R1: `mode` encodes 0 power-down, 1 standby, 2 acquire, 3 redriver and 4 retimer. Power-down is entered on the edge after any of these holds: `oe_in` low, `hpd_snk_in` low with the auto-disable bit clear, or the forced power-down bit set. In power-down `drv_en` and `cdr_en` are 0. A low `hpd_snk_in` with the auto-disable bit set does not power the path down.
- R2: With the signal-detect bit set and `clk_valid` low, the block enters standby with `drv_en` and `cdr_en` both 0. Power-down takes priority over standby, and `clk_valid` has no effect while signal detect is off.
- R3: Function mode 00 forces redriver and 11 forces retimer, whatever the measured rate. Both 01 and the reserved value 10 select automatic crossover.
- R4: In automatic crossover, a count below `LO_CNT` selects redriver. A count of `LO_CNT` or higher selects retimer, including counts far above the top of the rate range. The count in force is the one on `fcnt` in a strobe cycle, and otherwise the last strobed count.
- R5: Entering the retimer path from any other mode gives exactly `ACQ_CYC` cycles of acquire before retimer. The same happens when a strobed count differs from the previous count by more than `RATE_TOL` while in retimer. During acquire `cdr_en` is 1, and `drv_en` is 1 unless the blanking bit is set.
- R6: A strobed count within `RATE_TOL` of the previous count causes no acquisition. A qualifying rate change in the final acquire cycle restarts a full window.
- R7: `pol_swap_eff` follows the polarity bit only in acquire and retimer, and is 0 in redriver. `lane_swap_eff` follows the lane bit in acquire, redriver and retimer.
- R8: A new function mode takes effect only during power-down or on an edge of `hpd_snk_in`. A write alone leaves the path choice unchanged.
- R9: Writes are ignored while `oe_in` is low. `oe_in` low for `OE_MIN_CYC` consecutive clock edges resets the control word, the latched function mode and the stored count. A shorter low period keeps them.
- R10: `hpd_src` equals `hpd_snk_in` while the gate bit is clear, and is held 0 while it is set.
- R11: `sta_pd` is 1 only in power-down and `sta_sb` only in standby. Both read 0 in the passing and acquire modes.
- R12: While `rst_n` is low, `mode` is power-down. The control word resets to 0x001. Its fields are: [1:0] function mode, [2] forced power-down, [3] auto power-down disable, [4] signal detect, [5] acquire blanking, [6] polarity swap, [7] lane swap, [8] hot-plug gate. With all other bits 0 and no count strobed yet, the block settles in redriver after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_in | input | 1 | Output-enable pin level |
| hpd_snk_in | input | 1 | Sink hot-plug level |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word write data |
| clk_valid | input | 1 | Valid input clock seen by the activity detector |
| fcnt_vld | input | 1 | Strobe qualifying a new rate count |
| fcnt | input | FCNT_W | Pixel-clock count per reference window |
| mode | output | 3 | Current operating mode |
| drv_en | output | 1 | Output driver enable |
| cdr_en | output | 1 | CDR/PLL enable |
| pol_swap_eff | output | 1 | Polarity swap in effect |
| lane_swap_eff | output | 1 | Lane swap in effect |
| hpd_src | output | 1 | Hot-plug level forwarded to the source |
| sta_pd | output | 1 | Status: powered down |
| sta_sb | output | 1 | Status: standby |

## Verification
The acquisition timer's expiry and a fresh qualifying rate change can land in the same cycle. The restart has to win, or the path would report retimer lock on a stale rate. The bench provokes this by strobing a moved count exactly in the last acquire cycle of a window. It judges the result by counting twice `ACQ_CYC` consecutive acquire cycles before retimer appears. A second collision comes from the `oe_in` counter: the bench holds `oe_in` low for one edge fewer, and then exactly as many edges as needed, and checks whether polarity swap and the stored rate survive.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;

  typedef enum logic [2:0] {
    M_PDN  = 3'd0,
    M_STBY = 3'd1,
    M_ACQ  = 3'd2,
    M_RDRV = 3'd3,
    M_RTMR = 3'd4
  } mode_e;

  localparam logic [1:0] FM_RDRV = 2'b00;
  localparam logic [1:0] FM_AUTO = 2'b01;
  localparam logic [1:0] FM_RTMR = 2'b11;

  localparam int CFG_W = 9;

  typedef struct packed {
    logic       hpd_gate;
    logic       lane_sw;
    logic       pol_sw;
    logic       acq_blank;
    logic       sig_det;
    logic       auto_dis;
    logic       pd_force;
    logic [1:0] fmode;
  } cfg_t;

  localparam cfg_t CFG_RST = cfg_t'(9'h001);

endpackage

// File: rtl/rtmr_cfg_reg.sv
module rtmr_cfg_reg
  import rtmr_pkg::*;
#(
  parameter int OE_MIN_CYC = 2500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 oe_in,
  input  logic                 cfg_we,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output cfg_t                 cfg_q,
  output logic                 cfg_clr
);
  localparam int OW = $clog2(OE_MIN_CYC + 1);

  logic [OW-1:0] low_cnt;

  assign cfg_clr = !oe_in && (low_cnt == OW'(OE_MIN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (oe_in) begin
      low_cnt <= '0;
    end else if (low_cnt != OW'(OE_MIN_CYC)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (cfg_clr) begin
      cfg_q <= CFG_RST;
    end else if (cfg_we && oe_in) begin
      cfg_q <= cfg_t'(cfg_wdata);
    end
  end
endmodule

// File: rtl/rtmr_acq_timer.sv
module rtmr_acq_timer #(
  parameter int ACQ_CYC = 175000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int AW = $clog2(ACQ_CYC + 1);

  logic [AW-1:0] cnt;

  assign done = run && (cnt == AW'(ACQ_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && cnt != AW'(ACQ_CYC - 1)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtmr_mode_fsm.sv
module rtmr_mode_fsm
  import rtmr_pkg::*;
#(
  parameter int FCNT_W   = 12,
  parameter int LO_CNT   = 100,
  parameter int RATE_TOL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_clr,
  input  logic [1:0]        cfg_fmode,
  input  logic              cfg_pd_force,
  input  logic              cfg_auto_dis,
  input  logic              cfg_sig_det,
  input  logic              oe_in,
  input  logic              hpd_snk_in,
  input  logic              clk_valid,
  input  logic              fcnt_vld,
  input  logic [FCNT_W-1:0] fcnt,
  input  logic              acq_done,
  output mode_e             state_q,
  output logic              acq_start,
  output logic              rate_evt,
  output logic              want_rt
);
  function automatic logic pick_retimer(input logic [1:0] fm, input logic [FCNT_W-1:0] cnt);
    case (fm)
      FM_RDRV: return 1'b0;
      FM_RTMR: return 1'b1;
      default: return cnt >= FCNT_W'(LO_CNT);
    endcase
  endfunction

  function automatic logic rate_moved(input logic [FCNT_W-1:0] a, input logic [FCNT_W-1:0] b);
    logic [FCNT_W-1:0] d;
    d = (a >= b) ? (a - b) : (b - a);
    return d > FCNT_W'(RATE_TOL);
  endfunction

  logic [1:0]        eff_fm;
  logic [FCNT_W-1:0] last_fcnt;
  logic [FCNT_W-1:0] cur_fcnt;
  logic              hpd_q;
  logic              hpd_edge;
  logic              pd_cond;
  logic              stby_cond;
  mode_e             nxt;

  assign pd_cond   = !oe_in || (!hpd_snk_in && !cfg_auto_dis) || cfg_pd_force;
  assign stby_cond = cfg_sig_det && !clk_valid;
  assign hpd_edge  = hpd_q != hpd_snk_in;
  assign cur_fcnt  = fcnt_vld ? fcnt : last_fcnt;
  assign rate_evt  = fcnt_vld && rate_moved(fcnt, last_fcnt);
  assign want_rt   = pick_retimer(eff_fm, cur_fcnt);

  always_comb begin
    if (pd_cond) begin
      nxt = M_PDN;
    end else if (stby_cond) begin
      nxt = M_STBY;
    end else if (!want_rt) begin
      nxt = M_RDRV;
    end else begin
      case (state_q)
        M_RTMR:  nxt = rate_evt ? M_ACQ : M_RTMR;
        M_ACQ:   nxt = rate_evt ? M_ACQ : (acq_done ? M_RTMR : M_ACQ);
        default: nxt = M_ACQ;
      endcase
    end
  end

  assign acq_start = (nxt == M_ACQ) && ((state_q != M_ACQ) || rate_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= M_PDN;
    end else begin
      state_q <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_fm    <= FM_AUTO;
      last_fcnt <= '0;
      hpd_q     <= 1'b0;
    end else begin
      hpd_q <= hpd_snk_in;
      if (cfg_clr) begin
        eff_fm    <= FM_AUTO;
        last_fcnt <= '0;
      end else begin
        if (fcnt_vld) last_fcnt <= fcnt;
        if (pd_cond || hpd_edge) eff_fm <= cfg_fmode;
      end
    end
  end
endmodule

// File: rtl/rtmr_mode_ctrl.sv
module rtmr_mode_ctrl
  import rtmr_pkg::*;
#(
  parameter int FCNT_W     = 12,
  parameter int LO_CNT     = 100,
  parameter int RATE_TOL   = 4,
  parameter int ACQ_CYC    = 175000,
  parameter int OE_MIN_CYC = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oe_in,
  input  logic              hpd_snk_in,
  input  logic              cfg_we,
  input  logic [8:0]        cfg_wdata,
  input  logic              clk_valid,
  input  logic              fcnt_vld,
  input  logic [FCNT_W-1:0] fcnt,
  output logic [2:0]        mode,
  output logic              drv_en,
  output logic              cdr_en,
  output logic              pol_swap_eff,
  output logic              lane_swap_eff,
  output logic              hpd_src,
  output logic              sta_pd,
  output logic              sta_sb
);
  cfg_t  cfg_q;
  logic  cfg_clr;
  logic  acq_start;
  logic  acq_done;
  logic  rate_evt;
  logic  want_rt;
  mode_e state_q;
  logic  in_acq;
  logic  passing;

  rtmr_cfg_reg #(.OE_MIN_CYC(OE_MIN_CYC)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .oe_in     (oe_in),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cfg_clr   (cfg_clr)
  );

  rtmr_mode_fsm #(.FCNT_W(FCNT_W), .LO_CNT(LO_CNT), .RATE_TOL(RATE_TOL)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_clr      (cfg_clr),
    .cfg_fmode    (cfg_q.fmode),
    .cfg_pd_force (cfg_q.pd_force),
    .cfg_auto_dis (cfg_q.auto_dis),
    .cfg_sig_det  (cfg_q.sig_det),
    .oe_in        (oe_in),
    .hpd_snk_in   (hpd_snk_in),
    .clk_valid    (clk_valid),
    .fcnt_vld     (fcnt_vld),
    .fcnt         (fcnt),
    .acq_done     (acq_done),
    .state_q      (state_q),
    .acq_start    (acq_start),
    .rate_evt     (rate_evt),
    .want_rt      (want_rt)
  );

  assign in_acq = state_q == M_ACQ;

  rtmr_acq_timer #(.ACQ_CYC(ACQ_CYC)) u_acq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (acq_start),
    .run   (in_acq),
    .done  (acq_done)
  );

  assign passing       = (state_q == M_RDRV) || (state_q == M_RTMR);
  assign mode          = state_q;
  assign cdr_en        = in_acq || (state_q == M_RTMR);
  assign drv_en        = passing || (in_acq && !cfg_q.acq_blank);
  assign pol_swap_eff  = cdr_en && cfg_q.pol_sw;
  assign lane_swap_eff = (passing || in_acq) && cfg_q.lane_sw;
  assign hpd_src       = hpd_snk_in && !cfg_q.hpd_gate;
  assign sta_pd        = state_q == M_PDN;
  assign sta_sb        = state_q == M_STBY;
endmodule

// File: rtl/rtmr_mode_ctrl_chk.sv
module rtmr_mode_ctrl_chk #(
  parameter int ACQ_CYC = 175000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       oe_in,
  input logic       hpd_snk_in,
  input logic       hpd_src,
  input logic [2:0] mode,
  input logic       drv_en,
  input logic       cdr_en,
  input logic       pol_swap_eff,
  input logic       sta_pd,
  input logic       sta_sb,
  input logic       acq_start
);
  localparam int RW = $clog2(ACQ_CYC + 2);
  localparam logic [2:0] MD_PDN  = 3'd0;
  localparam logic [2:0] MD_STBY = 3'd1;
  localparam logic [2:0] MD_ACQ  = 3'd2;
  localparam logic [2:0] MD_RTMR = 3'd4;

  logic [RW-1:0] acq_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_run <= '0;
    end else if (acq_start) begin
      acq_run <= '0;
    end else if (mode == MD_ACQ && acq_run != RW'(ACQ_CYC)) begin
      acq_run <= acq_run + 1'b1;
    end
  end

  // R1
  oe_low_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_in |=> (mode == MD_PDN && !drv_en && !cdr_en));

  // R2
  stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_STBY) |-> (!drv_en && !cdr_en));

  // R5
  acq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_ACQ) |-> (acq_run < RW'(ACQ_CYC)));

  // R7
  pol_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_swap_eff |-> (mode == MD_ACQ || mode == MD_RTMR));

  // R10
  hpd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_src |-> hpd_snk_in);

  // R11
  stat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sta_pd, sta_sb}) && (sta_pd == (mode == MD_PDN)) && (sta_sb == (mode == MD_STBY)));
endmodule

bind rtmr_mode_ctrl rtmr_mode_ctrl_chk #(.ACQ_CYC(ACQ_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .oe_in        (oe_in),
  .hpd_snk_in   (hpd_snk_in),
  .hpd_src      (hpd_src),
  .mode         (mode),
  .drv_en       (drv_en),
  .cdr_en       (cdr_en),
  .pol_swap_eff (pol_swap_eff),
  .sta_pd       (sta_pd),
  .sta_sb       (sta_sb),
  .acq_start    (acq_start)
);

// File: tb/sim_rtmr_mode_ctrl.sv
module sim_rtmr_mode_ctrl;
  localparam int ACQ = 8;
  localparam int OEM = 16;
  localparam int FW  = 12;

  typedef struct packed {
    logic [8:0]    cfg;
    logic          clkv;
    logic [FW-1:0] fc;
    logic [2:0]    emode;
    logic          edrv;
    logic          ecdr;
    logic          epol;
    logic          elane;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{cfg:9'h001, clkv:1'b1, fc:12'd50,   emode:3'd3, edrv:1'b1, ecdr:1'b0, epol:1'b0, elane:1'b0}, // R4
    '{cfg:9'h001, clkv:1'b1, fc:12'd200,  emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b0, elane:1'b0}, // R4
    '{cfg:9'h041, clkv:1'b1, fc:12'd200,  emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b1, elane:1'b0}, // R7
    '{cfg:9'h041, clkv:1'b1, fc:12'd60,   emode:3'd3, edrv:1'b1, ecdr:1'b0, epol:1'b0, elane:1'b0}, // R7
    '{cfg:9'h040, clkv:1'b1, fc:12'd200,  emode:3'd3, edrv:1'b1, ecdr:1'b0, epol:1'b0, elane:1'b0}, // R3
    '{cfg:9'h043, clkv:1'b1, fc:12'd30,   emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b1, elane:1'b0}, // R3
    '{cfg:9'h002, clkv:1'b1, fc:12'd200,  emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b0, elane:1'b0}, // R3
    '{cfg:9'h002, clkv:1'b1, fc:12'd99,   emode:3'd3, edrv:1'b1, ecdr:1'b0, epol:1'b0, elane:1'b0}, // R4
    '{cfg:9'h001, clkv:1'b1, fc:12'd100,  emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b0, elane:1'b0}, // R4
    '{cfg:9'h001, clkv:1'b1, fc:12'd3000, emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b0, elane:1'b0}, // R4
    '{cfg:9'h011, clkv:1'b0, fc:12'd200,  emode:3'd1, edrv:1'b0, ecdr:1'b0, epol:1'b0, elane:1'b0}, // R2
    '{cfg:9'h001, clkv:1'b0, fc:12'd200,  emode:3'd4, edrv:1'b1, ecdr:1'b1, epol:1'b0, elane:1'b0}, // R2
    '{cfg:9'h005, clkv:1'b1, fc:12'd200,  emode:3'd0, edrv:1'b0, ecdr:1'b0, epol:1'b0, elane:1'b0}, // R1
    '{cfg:9'h0C1, clkv:1'b1, fc:12'd50,   emode:3'd3, edrv:1'b1, ecdr:1'b0, epol:1'b0, elane:1'b1}  // R7
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          oe_in = 1'b1;
  logic          hpd_snk_in = 1'b1;
  logic          cfg_we = 1'b0;
  logic [8:0]    cfg_wdata = 9'h001;
  logic          clk_valid = 1'b1;
  logic          fcnt_vld = 1'b0;
  logic [FW-1:0] fcnt = '0;
  logic [2:0]    mode;
  logic          drv_en, cdr_en, pol_swap_eff, lane_swap_eff, hpd_src, sta_pd, sta_sb;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rtmr_mode_ctrl #(
    .FCNT_W(FW), .LO_CNT(100), .RATE_TOL(4), .ACQ_CYC(ACQ), .OE_MIN_CYC(OEM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .oe_in(oe_in), .hpd_snk_in(hpd_snk_in),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clk_valid(clk_valid),
    .fcnt_vld(fcnt_vld), .fcnt(fcnt), .mode(mode), .drv_en(drv_en),
    .cdr_en(cdr_en), .pol_swap_eff(pol_swap_eff), .lane_swap_eff(lane_swap_eff),
    .hpd_src(hpd_src), .sta_pd(sta_pd), .sta_sb(sta_sb)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] w);
    cfg_wdata = w;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [8:0] w, input logic cv, input logic [FW-1:0] fc);
    wr(w | 9'h004);
    step();
    clk_valid = cv;
    fcnt = fc;
    fcnt_vld = 1'b1;
    step();
    fcnt_vld = 1'b0;
    wr(w);
    repeat (ACQ + 4) step();
  endtask

  task automatic pulse(input logic [FW-1:0] fc);
    fcnt = fc;
    fcnt_vld = 1'b1;
    step();
    fcnt_vld = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nacq;
    // R12 reset state
    step();
    step();
    chk(mode == 3'd0, "R12 mode in reset", mode, 0);
    chk(!drv_en && !cdr_en, "R12 enables in reset", {drv_en, cdr_en}, 0);
    chk(sta_pd && !sta_sb, "R11 status in reset", {sta_pd, sta_sb}, 2);
    rst_n = 1'b1;
    repeat (3) step();
    chk(mode == 3'd3, "R12 default settles to redriver", mode, 3);
    chk(!sta_pd && !sta_sb, "R11 status zero when passing", {sta_pd, sta_sb}, 0);
    chk(hpd_src == 1'b1, "R10 hot-plug passes by default", hpd_src, 1);

    // Table walk: R1 R2 R3 R4 R7
    for (int i = 0; i < NV; i++) begin
      apply(VT[i].cfg, VT[i].clkv, VT[i].fc);
      chk(mode == VT[i].emode, $sformatf("R3/R4 vector %0d mode", i), mode, VT[i].emode);
      chk(drv_en == VT[i].edrv && cdr_en == VT[i].ecdr,
          $sformatf("R1/R2 vector %0d enables", i), {drv_en, cdr_en}, {VT[i].edrv, VT[i].ecdr});
      chk(pol_swap_eff == VT[i].epol && lane_swap_eff == VT[i].elane,
          $sformatf("R7 vector %0d swaps", i), {pol_swap_eff, lane_swap_eff}, {VT[i].epol, VT[i].elane});
      chk(sta_pd == (VT[i].emode == 3'd0) && sta_sb == (VT[i].emode == 3'd1),
          $sformatf("R11 vector %0d status", i), {sta_pd, sta_sb}, {VT[i].emode == 3'd0, VT[i].emode == 3'd1});
    end
    clk_valid = 1'b1;

    // R5 window length, outputs active by default
    apply(9'h001, 1'b1, 12'd50);
    pulse(12'd200);
    nacq = 0;
    for (int k = 0; k < 20; k++) begin
      if (mode == 3'd2) begin
        nacq++;
        chk(drv_en && cdr_en, "R5 drivers and CDR on in acquire", {drv_en, cdr_en}, 3);
      end
      step();
    end
    chk(nacq == ACQ, "R5 acquire length", nacq, ACQ);
    chk(mode == 3'd4, "R5 retimer after acquire", mode, 4);

    // R5 blanking
    apply(9'h021, 1'b1, 12'd50);
    pulse(12'd200);
    chk(mode == 3'd2 && !drv_en && cdr_en, "R5 blanked acquire", {mode, drv_en, cdr_en}, {3'd2, 2'b01});
    repeat (ACQ + 2) step();
    chk(mode == 3'd4 && drv_en, "R5 drivers back after blanking", {mode, drv_en}, {3'd4, 1'b1});

    // R6 within tolerance, then beyond
    pulse(12'd203);
    chk(mode == 3'd4, "R6 small move keeps retimer", mode, 4);
    pulse(12'd215);
    chk(mode == 3'd2, "R6 large move reacquires", mode, 2);
    repeat (ACQ + 2) step();

    // R6 rate change on final acquire cycle restarts the window
    fcnt = 12'd260;
    fcnt_vld = 1'b1;
    nacq = 0;
    for (int k = 1; k <= 30; k++) begin
      step();
      fcnt_vld = (k == 8);
      if (k == 8) fcnt = 12'd320;
      if (mode == 3'd2) nacq++;
    end
    chk(nacq == 2 * ACQ, "R6 restart on final cycle", nacq, 2 * ACQ);

    // R8 crossover latch
    wr(9'h000);
    repeat (10) step();
    chk(mode == 3'd4, "R8 new mode not yet applied", mode, 4);
    hpd_snk_in = 1'b0;
    step();
    hpd_snk_in = 1'b1;
    repeat (4) step();
    chk(mode == 3'd3, "R8 applied after hot-plug toggle", mode, 3);

    // R1 auto-disable, then hot-plug power-down
    apply(9'h00B, 1'b1, 12'd200);
    hpd_snk_in = 1'b0;
    repeat (3) step();
    chk(mode == 3'd4, "R1 auto-disable keeps path up", mode, 4);
    chk(hpd_src == 1'b0, "R10 low hot-plug forwarded", hpd_src, 0);
    hpd_snk_in = 1'b1;
    wr(9'h003);
    hpd_snk_in = 1'b0;
    repeat (2) step();
    chk(mode == 3'd0 && sta_pd, "R1 hot-plug low powers down", mode, 0);
    hpd_snk_in = 1'b1;

    // R10 gate
    wr(9'h103);
    chk(hpd_src == 1'b0, "R10 gate holds source low", hpd_src, 0);
    wr(9'h003);
    chk(hpd_src == 1'b1, "R10 gate released", hpd_src, 1);

    // R2 power-down priority over standby
    apply(9'h015, 1'b0, 12'd200);
    chk(mode == 3'd0, "R2 power-down beats standby", mode, 0);
    clk_valid = 1'b1;

    // R9 short OE low with an ignored write
    apply(9'h043, 1'b1, 12'd200);
    oe_in = 1'b0;
    step();
    cfg_wdata = 9'h005;
    cfg_we = 1'b1;
    step();
    cfg_we = 1'b0;
    repeat (OEM - 3) step();
    chk(mode == 3'd0, "R1 OE low powers down", mode, 0);
    oe_in = 1'b1;
    repeat (ACQ + 4) step();
    chk(mode == 3'd4 && pol_swap_eff, "R9 short OE keeps config, write ignored",
        {mode, pol_swap_eff}, {3'd4, 1'b1});

    // R9 OE low exactly long enough
    oe_in = 1'b0;
    repeat (OEM) step();
    oe_in = 1'b1;
    repeat (ACQ + 4) step();
    chk(mode == 3'd3 && !pol_swap_eff, "R9 long OE restores defaults",
        {mode, pol_swap_eff}, {3'd3, 1'b0});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule